// File: doc/BRIEF.md
# Control Endpoint Stage Tracker

This block follows a control transfer on endpoint 0 of a USB device controller through its stages. Firmware-side logic or the packet engine feeds it single-cycle event strobes: a SETUP packet arrived, an IN data packet went out, an OUT data packet came in, the last IN packet's completion interrupt fired, and software asks for a stall. With each SETUP it also receives the direction and the requested length (wLength) taken from the setup packet. It counts the data bytes against that length and reports the current stage as a 3-bit code. It also raises a stall flag and emits a one-cycle pulse that starts the status stage.

The pulse can be held back by a delayed-status flag that software sets and later releases. The block also includes a six-byte response buffer. Locally answered standard requests are staged in it: a GET_STATUS reply uses two bytes and a SET_SEL payload uses six.

Top module: `ep0_ctrl_stage`

## Requirements
- R1: While reset is asserted and after it is released, stage_o is 1 (SETUP), stall_o is 0 and status_o is 0.
- R2: Stage codes on stage_o are SETUP=1, TX=2, RX=3, TX_END=4, STALL=5. When setup_i arrives with a nonzero len_i, the next stage is TX if dir_in_i is 1 and RX if it is 0.
- R3: When setup_i arrives with len_i of 0, the stage stays SETUP and status_o pulses high in the cycle after the strobe.
- R4: In TX, each in_done_i adds pkt_len_i to a byte count. The stage moves to TX_END when the count reaches len_i or when pkt_len_i is below MPS (a short packet). Otherwise it stays in TX.
- R5: TX_END is left for SETUP only on tx_cmpl_i, and status_o pulses in the next cycle. in_done_i and out_rx_i have no effect while in TX_END.
- R6: In RX, each out_rx_i adds pkt_len_i to the byte count. The stage returns to SETUP, with a status_o pulse, when the count reaches len_i or when a short packet arrives.
- R7: stall_req_i moves any stage to STALL in the next cycle, and stall_o then reads 1.
- R8: STALL is left only by setup_i, which is decoded as in R2 and R3. tx_cmpl_i, in_done_i and out_rx_i leave STALL unchanged.
- R9: When setup_i and stall_req_i occur in the same cycle, the stall wins and the stage becomes STALL.
- R10: When delay_set_i is pending, a completion that would pulse status_o does not pulse it. The first later delay_clr_i produces exactly one status_o pulse in the cycle after it.
- R11: The response buffer has 6 byte entries at indices 0..5, written on buf_wr_i and read combinationally. Writes to index 6 or 7 are ignored, and reads of those indices return 0.
- R12: setup_i arriving in TX, RX or TX_END abandons the current transfer and decodes the new request with a byte count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_i | input | 1 | SETUP packet received strobe |
| dir_in_i | input | 1 | Data direction from the setup packet, 1 = IN |
| len_i | input | LEN_W | Requested data length from the setup packet |
| in_done_i | input | 1 | IN data packet sent strobe |
| out_rx_i | input | 1 | OUT data packet received strobe |
| pkt_len_i | input | PKT_W | Byte count of the packet carried by in_done_i or out_rx_i |
| tx_cmpl_i | input | 1 | Completion interrupt of the last IN packet |
| stall_req_i | input | 1 | Software stall request |
| delay_set_i | input | 1 | Hold off the status stage |
| delay_clr_i | input | 1 | Release a held status stage |
| buf_wr_i | input | 1 | Response buffer write enable |
| buf_wr_idx_i | input | BUF_IDX_W | Response buffer write index |
| buf_wr_data_i | input | 8 | Response buffer write byte |
| buf_rd_idx_i | input | BUF_IDX_W | Response buffer read index |
| buf_rd_data_o | output | 8 | Response buffer read byte |
| stage_o | output | 3 | Current stage code |
| stall_o | output | 1 | Endpoint is stalled |
| status_o | output | 1 | One-cycle status-stage trigger |

## Verification
The collision that matters is a SETUP arriving in the same cycle as a software stall request. Both strobes try to set the next stage, one toward a decoded data stage and one toward STALL. The bench provokes this by raising setup_i and stall_req_i together while already stalled, with a zero-length request that would otherwise trigger a status pulse. It judges the result by expecting stage 5, stall_o high and status_o low afterwards. It then sends a lone SETUP to show that this alone releases the stall.

// File: rtl/ep0_stage_pkg.sv
package ep0_stage_pkg;
  typedef enum logic [2:0] {
    ST_SETUP  = 3'd1,
    ST_TX     = 3'd2,
    ST_RX     = 3'd3,
    ST_TX_END = 3'd4,
    ST_STALL  = 3'd5
  } ep0_stage_e;
endpackage

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_stage_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS   = 64,
  parameter int PKT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_i,
  input  logic             dir_in_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_done_i,
  input  logic             out_rx_i,
  input  logic [PKT_W-1:0] pkt_len_i,
  input  logic             tx_cmpl_i,
  input  logic             stall_req_i,
  output ep0_stage_e       stage_o,
  output logic             done_o
);
  localparam int SUM_W = LEN_W + 1;

  ep0_stage_e       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d;
  logic [SUM_W-1:0] sum;
  logic             last_pkt;

  always_comb begin
    sum      = {1'b0, cnt_q} + SUM_W'(pkt_len_i);
    last_pkt = (sum >= {1'b0, len_q}) || (pkt_len_i < PKT_W'(MPS));
    state_d  = state_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    done_o   = 1'b0;
    if (stall_req_i) begin
      state_d = ST_STALL;
    end else if (setup_i) begin
      len_d = len_i;
      cnt_d = '0;
      if (len_i == '0) begin
        state_d = ST_SETUP;
        done_o  = 1'b1;
      end else begin
        state_d = dir_in_i ? ST_TX : ST_RX;
      end
    end else begin
      unique case (state_q)
        ST_TX: if (in_done_i) begin
          cnt_d = sum[LEN_W-1:0];
          if (last_pkt) state_d = ST_TX_END;
        end
        ST_RX: if (out_rx_i) begin
          cnt_d = sum[LEN_W-1:0];
          if (last_pkt) begin
            state_d = ST_SETUP;
            done_o  = 1'b1;
          end
        end
        ST_TX_END: if (tx_cmpl_i) begin
          state_d = ST_SETUP;
          done_o  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SETUP;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
    end
  end

  assign stage_o = state_q;
endmodule

// File: rtl/ep0_status_gate.sv
module ep0_status_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic setup_i,
  input  logic stall_i,
  input  logic delay_set_i,
  input  logic delay_clr_i,
  output logic status_o
);
  logic delay_q, pend_q, status_q;
  logic hold, release_ok, fire;

  always_comb begin
    hold       = delay_set_i | (delay_q & ~delay_clr_i & ~setup_i);
    // a held status survives only while no new request or stall intervenes
    release_ok = pend_q & delay_q & delay_clr_i & ~setup_i & ~stall_i & ~delay_set_i;
    fire       = (done_i & ~hold) | release_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_q  <= 1'b0;
      pend_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      delay_q  <= hold & ~stall_i;
      status_q <= fire;
      if (stall_i)                pend_q <= 1'b0;
      else if (done_i && hold)    pend_q <= 1'b1;
      else if (setup_i || release_ok) pend_q <= 1'b0;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/ep0_resp_buf.sv
module ep0_resp_buf #(
  parameter int DEPTH = 6,
  parameter int DW    = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[g] <= '0;
      else if (wr_i && (wr_idx_i == IDX_W'(g)))        mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = mem_q[i];
  end
endmodule

// File: rtl/ep0_ctrl_stage.sv
module ep0_ctrl_stage
  import ep0_stage_pkg::*;
#(
  parameter  int LEN_W     = 16,
  parameter  int MPS       = 64,
  parameter  int BUF_DEPTH = 6,
  localparam int PKT_W     = $clog2(MPS + 1),
  localparam int BUF_IDX_W = $clog2(BUF_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 setup_i,
  input  logic                 dir_in_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 in_done_i,
  input  logic                 out_rx_i,
  input  logic [PKT_W-1:0]     pkt_len_i,
  input  logic                 tx_cmpl_i,
  input  logic                 stall_req_i,
  input  logic                 delay_set_i,
  input  logic                 delay_clr_i,
  input  logic                 buf_wr_i,
  input  logic [BUF_IDX_W-1:0] buf_wr_idx_i,
  input  logic [7:0]           buf_wr_data_i,
  input  logic [BUF_IDX_W-1:0] buf_rd_idx_i,
  output logic [7:0]           buf_rd_data_o,
  output logic [2:0]           stage_o,
  output logic                 stall_o,
  output logic                 status_o
);
  ep0_stage_e stage;
  logic       done;

  ep0_stage_fsm #(.LEN_W(LEN_W), .MPS(MPS), .PKT_W(PKT_W)) u_fsm (
    .clk_i, .rst_ni, .setup_i, .dir_in_i, .len_i, .in_done_i, .out_rx_i,
    .pkt_len_i, .tx_cmpl_i, .stall_req_i,
    .stage_o (stage),
    .done_o  (done)
  );

  ep0_status_gate u_gate (
    .clk_i, .rst_ni,
    .done_i      (done),
    .setup_i,
    .stall_i     (stall_req_i),
    .delay_set_i, .delay_clr_i,
    .status_o
  );

  ep0_resp_buf #(.DEPTH(BUF_DEPTH), .DW(8), .IDX_W(BUF_IDX_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_i      (buf_wr_i),
    .wr_idx_i  (buf_wr_idx_i),
    .wr_data_i (buf_wr_data_i),
    .rd_idx_i  (buf_rd_idx_i),
    .rd_data_o (buf_rd_data_o)
  );

  assign stage_o = stage;
  assign stall_o = (stage == ST_STALL);
endmodule

// File: rtl/ep0_ctrl_stage_chk.sv
module ep0_ctrl_stage_chk
  import ep0_stage_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             setup_i,
  input logic [LEN_W-1:0] len_i,
  input logic             tx_cmpl_i,
  input logic             stall_req_i,
  input logic             delay_set_i,
  input logic             buf_wr_i,
  input logic [IDX_W-1:0] buf_wr_idx_i,
  input logic [7:0]       buf_wr_data_i,
  input logic [IDX_W-1:0] buf_rd_idx_i,
  input logic [7:0]       buf_rd_data_o,
  input logic [2:0]       stage_o,
  input logic             stall_o,
  input logic             status_o
);
  // R7
  stall_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_req_i |=> (stage_o == ST_STALL) && stall_o);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == ST_STALL) && !setup_i |=> (stage_o == ST_STALL));

  // R5
  tx_end_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == ST_TX_END) && !tx_cmpl_i && !setup_i && !stall_req_i
      |=> (stage_o == ST_TX_END) && !status_o);

  // R3
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i && (len_i == '0) && !stall_req_i && !delay_set_i
      |=> status_o && (stage_o == ST_SETUP));

  // R10
  status_in_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> (stage_o == ST_SETUP));

  // R11
  buf_wr_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_i && (buf_wr_idx_i < IDX_W'(6)) && (buf_wr_idx_i == buf_rd_idx_i)
      ##1 $stable(buf_rd_idx_i) |-> buf_rd_data_o == $past(buf_wr_data_i));
endmodule

bind ep0_ctrl_stage ep0_ctrl_stage_chk #(.LEN_W(LEN_W), .IDX_W(BUF_IDX_W)) u_chk (
  .clk_i, .rst_ni, .setup_i, .len_i, .tx_cmpl_i, .stall_req_i, .delay_set_i,
  .buf_wr_i, .buf_wr_idx_i, .buf_wr_data_i, .buf_rd_idx_i, .buf_rd_data_o,
  .stage_o, .stall_o, .status_o
);

// File: tb/ep0_ctrl_stage_tb.sv
module ep0_ctrl_stage_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        setup_i, dir_in_i, in_done_i, out_rx_i, tx_cmpl_i, stall_req_i;
  logic        delay_set_i, delay_clr_i, buf_wr_i;
  logic [15:0] len_i;
  logic [6:0]  pkt_len_i;
  logic [2:0]  buf_wr_idx_i, buf_rd_idx_i, stage_o;
  logic [7:0]  buf_wr_data_i, buf_rd_data_o;
  logic        stall_o, status_o;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ep0_ctrl_stage u_dut (.*);

  typedef struct packed {
    logic su; logic di; logic [15:0] ln; logic ind; logic orx; logic [6:0] pk;
    logic cm; logic st; logic [2:0] es; logic estl; logic ests;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,16'd100,1'b0,1'b0,7'd0, 1'b0,1'b0,3'd2,1'b0,1'b0}, // R2 IN -> TX
    '{1'b0,1'b0,16'd0,  1'b1,1'b0,7'd64,1'b0,1'b0,3'd2,1'b0,1'b0}, // R4 64<100 stay
    '{1'b0,1'b0,16'd0,  1'b1,1'b0,7'd36,1'b0,1'b0,3'd4,1'b0,1'b0}, // R4 short -> TX_END
    '{1'b0,1'b0,16'd0,  1'b1,1'b0,7'd64,1'b0,1'b0,3'd4,1'b0,1'b0}, // R5 in_done ignored
    '{1'b0,1'b0,16'd0,  1'b0,1'b0,7'd0, 1'b1,1'b0,3'd1,1'b0,1'b1}, // R5 cmpl -> SETUP
    '{1'b0,1'b0,16'd0,  1'b0,1'b0,7'd0, 1'b0,1'b0,3'd1,1'b0,1'b0}, // R3 pulse ends
    '{1'b1,1'b0,16'd128,1'b0,1'b0,7'd0, 1'b0,1'b0,3'd3,1'b0,1'b0}, // R2 OUT -> RX
    '{1'b0,1'b0,16'd0,  1'b0,1'b1,7'd64,1'b0,1'b0,3'd3,1'b0,1'b0}, // R6 partial
    '{1'b0,1'b0,16'd0,  1'b0,1'b1,7'd64,1'b0,1'b0,3'd1,1'b0,1'b1}, // R6 length reached
    '{1'b1,1'b0,16'd200,1'b0,1'b0,7'd0, 1'b0,1'b0,3'd3,1'b0,1'b0}, // R2
    '{1'b0,1'b0,16'd0,  1'b0,1'b1,7'd10,1'b0,1'b0,3'd1,1'b0,1'b1}, // R6 short packet
    '{1'b1,1'b1,16'd0,  1'b0,1'b0,7'd0, 1'b0,1'b0,3'd1,1'b0,1'b1}, // R3 zero length
    '{1'b1,1'b1,16'd64, 1'b0,1'b0,7'd0, 1'b0,1'b0,3'd2,1'b0,1'b0}, // R2
    '{1'b0,1'b0,16'd0,  1'b1,1'b0,7'd64,1'b0,1'b0,3'd4,1'b0,1'b0}, // R4 exact full packet
    '{1'b1,1'b0,16'd8,  1'b0,1'b0,7'd0, 1'b0,1'b0,3'd3,1'b0,1'b0}, // R12 from TX_END
    '{1'b1,1'b1,16'd8,  1'b0,1'b0,7'd0, 1'b0,1'b0,3'd2,1'b0,1'b0}, // R12 from RX
    '{1'b0,1'b0,16'd0,  1'b0,1'b0,7'd0, 1'b0,1'b1,3'd5,1'b1,1'b0}, // R7 from TX
    '{1'b0,1'b0,16'd0,  1'b0,1'b0,7'd0, 1'b1,1'b0,3'd5,1'b1,1'b0}, // R8 cmpl ignored
    '{1'b0,1'b0,16'd0,  1'b0,1'b1,7'd5, 1'b0,1'b0,3'd5,1'b1,1'b0}, // R8 out ignored
    '{1'b1,1'b1,16'd0,  1'b0,1'b0,7'd0, 1'b0,1'b1,3'd5,1'b1,1'b0}, // R9 stall beats setup
    '{1'b1,1'b0,16'd0,  1'b0,1'b0,7'd0, 1'b0,1'b0,3'd1,1'b0,1'b1}, // R8 setup leaves
    '{1'b1,1'b1,16'd16, 1'b0,1'b0,7'd0, 1'b0,1'b0,3'd2,1'b0,1'b0}, // R2
    '{1'b0,1'b0,16'd0,  1'b0,1'b0,7'd0, 1'b0,1'b1,3'd5,1'b1,1'b0}, // R7
    '{1'b1,1'b1,16'd16, 1'b0,1'b0,7'd0, 1'b0,1'b0,3'd2,1'b0,1'b0}  // R8 to TX
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    {setup_i, dir_in_i, in_done_i, out_rx_i, tx_cmpl_i, stall_req_i} = '0;
    {delay_set_i, delay_clr_i, buf_wr_i} = '0;
    len_i = '0; pkt_len_i = '0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    buf_wr_idx_i = '0; buf_wr_data_i = '0; buf_rd_idx_i = '0;
    repeat (3) @(negedge clk_i);
    check("R1 stage in reset", 16'(stage_o), 16'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 stage", 16'(stage_o), 16'd1);
    check("R1 stall", 16'(stall_o), 16'd0);
    check("R1 status", 16'(status_o), 16'd0);

    for (int v = 0; v < NV; v++) begin
      setup_i = VEC[v].su; dir_in_i = VEC[v].di; len_i = VEC[v].ln;
      in_done_i = VEC[v].ind; out_rx_i = VEC[v].orx; pkt_len_i = VEC[v].pk;
      tx_cmpl_i = VEC[v].cm; stall_req_i = VEC[v].st;
      @(negedge clk_i);
      check($sformatf("vec%0d stage", v), 16'(stage_o), 16'(VEC[v].es));
      check($sformatf("vec%0d stall", v), 16'(stall_o), 16'(VEC[v].estl));
      check($sformatf("vec%0d status", v), 16'(status_o), 16'(VEC[v].ests));
    end
    idle();

    // R10 delayed status on a zero-length request
    setup_i = 1'b1; delay_set_i = 1'b1;
    @(negedge clk_i); idle();
    check("R10 held stage", 16'(stage_o), 16'd1);
    check("R10 held status", 16'(status_o), 16'd0);
    @(negedge clk_i);
    check("R10 still held", 16'(status_o), 16'd0);
    delay_clr_i = 1'b1;
    @(negedge clk_i); idle();
    check("R10 released", 16'(status_o), 16'd1);
    @(negedge clk_i);
    check("R10 single pulse", 16'(status_o), 16'd0);
    delay_clr_i = 1'b1;
    @(negedge clk_i); idle();
    check("R10 no second pulse", 16'(status_o), 16'd0);

    // R11 response buffer
    for (int i = 0; i < 6; i++) begin
      buf_wr_i = 1'b1; buf_wr_idx_i = 3'(i); buf_wr_data_i = 8'(8'hA0 + i);
      @(negedge clk_i);
    end
    buf_wr_i = 1'b1; buf_wr_idx_i = 3'd6; buf_wr_data_i = 8'h55;
    @(negedge clk_i);
    buf_wr_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      buf_rd_idx_i = 3'(i);
      #1;
      check($sformatf("R11 read %0d", i), 16'(buf_rd_data_o),
            (i < 6) ? 16'(8'hA0 + i) : 16'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule